// File: doc/BRIEF.md
# Paced Two-Channel DMA Engine

This block holds two independent transfer channels that move words across a single-beat memory bus without processor help. Each transfer is a read beat followed by a write beat. A channel can fill memory from a peripheral, drain memory into a peripheral, or copy one memory region to another. A peripheral is reached through an ordinary bus address, and a per-channel option pins the peripheral-side address so that every beat hits the same data register.

Software sets up a channel through a small register port and then sets its enable bit. The channel paces itself in one of three ways. It can run at the full rate the bus allows. It can wait a programmed number of idle cycles between words. It can move exactly one word per pulse on its event input, where the pulse might come from a timer tick or a pin edge. When a channel finishes it can start its partner. If both channels are set up this way with interrupts enabled, the pair forms a ping-pong loop: software reloads the idle channel while the other one runs.

Top module: `pdma_top`

## Requirements
- R1: After synchronous reset every register reads zero, `bus_req` is low and `irq` is low.
- R2: A copy (op code 2) of N words reads source addresses S..S+N-1 and writes the values read to D..D+N-1, in that order. When the copy ends, the source register reads S+N.
- R3: CTRL bit 5 (fix) holds the peripheral side still. In op 0 (peripheral to memory) the source address stays constant. In op 1 (memory to peripheral) the destination address stays constant. The other side still increments by one.
- R4: In trigger mode 0 (free-run) on an uncontended bus, successive write beats of a channel are exactly 4 cycles apart.
- R5: In trigger mode 1 (throttled) with GAP register value G, successive write beats are exactly 4+G cycles apart.
- R6: In trigger mode 2 (event) no word moves without a pulse, and each cycle in which `ev_pulse[c]` is high allows exactly one word on channel c.
- R7: While a word is in flight, pulses are queued up to 4 deep and are not dropped. Pulses beyond 4 pending are lost.
- R8: When a channel with CTRL bit 6 (link) completes its last word, the other channel starts, provided that it is idle and its count is non-zero.
- R9: In a ping-pong pair (both channels linked, CTRL bit 7 irq-enable set), each completion starts the partner and raises `irq`. The finished channel may then be reloaded while the partner runs.
- R10: When both channels request the bus in the same cycle, channel 0 is granted.
- R11: Writes to a channel's registers while it is busy have no effect. COUNT reads back the remaining words. Setting enable with COUNT zero leaves the channel idle.
- R12: Status bit c (register index 5) sets when channel c completes and stays set until 1 is written to it. `irq` is the OR of the status bits whose channel has irq-enable set.

Register address is {channel, index}. The indices are: 0 CTRL, 1 SRC, 2 DST, 3 COUNT, 4 GAP, and 5 STATUS, which is shared by both channels. CTRL fields: bit 0 enable (reads back busy), bits 2:1 op, bits 4:3 trigger, bit 5 fix, bit 6 link, bit 7 irq-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {channel, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ev_pulse | input | 2 | Per-channel event pulse, one word per high cycle |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 16 | Beat word address |
| bus_wdata | output | 32 | Write beat data |
| bus_gnt | input | 1 | Beat accepted in this cycle |
| bus_rdata | input | 32 | Read data, valid the cycle after a read grant |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that collide are the two channels' bus requests. The bench provokes this by holding the grant low while channel 1 and then channel 0 start, so that both sit requesting in the same cycle. It judges the outcome by the address on the bus when the grant is released and by the copied data of both channels. A second overlap occurs when event pulses arrive while a word is stalled on the bus; the bench judges it by the remaining count once the stall is lifted.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int NCH   = 2;
    localparam int CH_W  = 1;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SRC  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DST  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CNT  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_GAP  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd5;

    typedef enum logic [1:0] {
        OP_P2M = 2'd0,
        OP_M2P = 2'd1,
        OP_M2M = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        TRG_FREE  = 2'd0,
        TRG_THROT = 2'd1,
        TRG_EVENT = 2'd2
    } trig_e;

    typedef struct packed {
        logic  irq_en;
        logic  link;
        logic  fix;
        trig_e trig;
        op_e   op;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD,
        ST_RDW,
        ST_WR
    } st_e;

    function automatic logic src_moves(ctrl_t c);
        return !(c.fix && c.op == OP_P2M);
    endfunction

    function automatic logic dst_moves(ctrl_t c);
        return !(c.fix && c.op == OP_M2P);
    endfunction

endpackage

// File: rtl/pdma_evcnt.sv
module pdma_evcnt #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic add,
    input  logic take,
    output logic nz
);
    localparam int W = $clog2(DEPTH + 1);

    logic [W-1:0] n;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n <= '0;
        end else if (add && !take && n != W'(DEPTH)) begin
            n <= n + W'(1);
        end else if (take && !add) begin
            n <= n - W'(1);
        end
    end

    assign nz = (n != '0);

    AST_EV_BOUND: assert property (@(posedge clk) disable iff (rst)
        n <= W'(DEPTH)); // R7
    AST_EV_KEEP: assert property (@(posedge clk) disable iff (rst)
        (add && !take && !clr && n != '0) |=> n != '0); // R7
    AST_EV_TAKE_NZ: assert property (@(posedge clk) disable iff (rst)
        take |-> nz); // R6

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int GW  = 8,
    parameter int EVD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             start_in,
    input  logic             ev_in,
    input  logic             gnt,
    input  logic [DW-1:0]    rdata,
    output logic             req,
    output logic             we,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata,
    output logic             done,
    output logic             busy,
    output ctrl_t            ctrl_o,
    output logic [AW-1:0]    src_o,
    output logic [AW-1:0]    dst_o,
    output logic [CW-1:0]    cnt_o,
    output logic [GW-1:0]    gap_o
);
    st_e            st;
    ctrl_t          ctrl;
    logic [AW-1:0]  src, dst;
    logic [CW-1:0]  cnt;
    logic [GW-1:0]  gap, gap_cnt;
    logic [DW-1:0]  data_q;

    logic idle, paced, ev_nz, ev_take, ev_add, gate_open, last, launch;

    assign idle      = (st == ST_IDLE);
    assign paced     = (ctrl.trig == TRG_EVENT);
    assign gate_open = (gap_cnt == '0) && (!paced || ev_nz);
    assign last      = (cnt == CW'(1));
    assign launch    = idle && (cnt != '0) &&
                       (start_in || (wr_en && wr_idx == IDX_CTRL && wr_data[0]));
    assign ev_add    = ev_in && paced && !idle;
    assign ev_take   = (st == ST_ARM) && gate_open && paced;

    pdma_evcnt #(.DEPTH(EVD)) i_evcnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (idle),
        .add  (ev_add),
        .take (ev_take),
        .nz   (ev_nz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctrl    <= '0;
            src     <= '0;
            dst     <= '0;
            cnt     <= '0;
            gap     <= '0;
            gap_cnt <= '0;
            data_q  <= '0;
        end else begin
            if (idle && wr_en) begin
                case (wr_idx)
                    IDX_CTRL: ctrl <= ctrl_t'(wr_data[7:1]);
                    IDX_SRC:  src  <= wr_data[AW-1:0];
                    IDX_DST:  dst  <= wr_data[AW-1:0];
                    IDX_CNT:  cnt  <= wr_data[CW-1:0];
                    IDX_GAP:  gap  <= wr_data[GW-1:0];
                    default: ;
                endcase
            end
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        st      <= ST_ARM;
                        gap_cnt <= '0;
                    end
                end
                ST_ARM: begin
                    if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - GW'(1);
                    end else if (gate_open) begin
                        st <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (gnt) st <= ST_RDW;
                end
                ST_RDW: begin
                    data_q <= rdata;
                    st     <= ST_WR;
                end
                ST_WR: begin
                    if (gnt) begin
                        src <= src + AW'(src_moves(ctrl));
                        dst <= dst + AW'(dst_moves(ctrl));
                        cnt <= cnt - CW'(1);
                        if (last) begin
                            st <= ST_IDLE;
                        end else begin
                            st      <= ST_ARM;
                            gap_cnt <= (ctrl.trig == TRG_THROT) ? gap : '0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req    = (st == ST_RD) || (st == ST_WR);
    assign we     = (st == ST_WR);
    assign addr   = (st == ST_WR) ? dst : src;
    assign wdata  = data_q;
    assign done   = (st == ST_WR) && gnt && last;
    assign busy   = !idle;
    assign ctrl_o = ctrl;
    assign src_o  = src;
    assign dst_o  = dst;
    assign cnt_o  = cnt;
    assign gap_o  = gap;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req); // R1
    AST_BUSY_CNT: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt != '0); // R11
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(gap)); // R11
    AST_FIX_SRC: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR && gnt && ctrl.fix && ctrl.op == OP_P2M) |=> $stable(src)); // R3
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARM && gap_cnt != '0) |=> st == ST_ARM); // R5
    AST_EVENT_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARM && paced && !ev_nz) |=> st == ST_ARM); // R6

endmodule

// File: rtl/pdma_arb.sv
module pdma_arb
    import pdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0]           ch_req,
    input  logic [NCH-1:0]           ch_we,
    input  logic [NCH-1:0][AW-1:0]   ch_addr,
    input  logic [NCH-1:0][DW-1:0]   ch_wdata,
    input  logic                     bus_gnt,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [AW-1:0]            bus_addr,
    output logic [DW-1:0]            bus_wdata,
    output logic [NCH-1:0]           ch_gnt
);
    logic [CH_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_req[i]) sel = CH_W'(i);
        end
        ch_gnt      = '0;
        ch_gnt[sel] = bus_gnt && ch_req[sel];
    end

    assign bus_req   = |ch_req;
    assign bus_we    = ch_we[sel];
    assign bus_addr  = ch_addr[sel];
    assign bus_wdata = ch_wdata[sel];

    AST_PRIO_CH0: assert property (@(posedge clk) disable iff (rst)
        ch_req[0] |-> !ch_gnt[1]); // R10
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_gnt)); // R10
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ch_gnt[1] |-> ch_req[1]); // R10

endmodule

// File: rtl/pdma_top.sv
module pdma_top
    import pdma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int GW  = 8,
    parameter int EVD = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [CH_W+IDX_W-1:0] reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [NCH-1:0]        ev_pulse,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [AW-1:0]         bus_addr,
    output logic [DW-1:0]         bus_wdata,
    input  logic                  bus_gnt,
    input  logic [DW-1:0]         bus_rdata,
    output logic                  irq
);
    logic [IDX_W-1:0]         idx;
    logic [CH_W-1:0]          csel;
    logic [NCH-1:0]           ch_req, ch_we, ch_gnt, done, busy, start, ien, link;
    logic [NCH-1:0][AW-1:0]   ch_addr, src_v, dst_v;
    logic [NCH-1:0][DW-1:0]   ch_wdata;
    logic [NCH-1:0][CW-1:0]   cnt_v;
    logic [NCH-1:0][GW-1:0]   gap_v;
    ctrl_t                    ctrl_v [NCH];
    logic [NCH-1:0]           stat, clr_mask;

    assign idx  = reg_addr[IDX_W-1:0];
    assign csel = reg_addr[IDX_W +: CH_W];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int PARTNER = (g + 1) % NCH;
        logic wr_sel;
        assign wr_sel   = reg_we && (csel == CH_W'(g)) && (idx < IDX_STAT);
        assign start[g] = done[PARTNER] && link[PARTNER];
        assign ien[g]   = ctrl_v[g].irq_en;
        assign link[g]  = ctrl_v[g].link;

        pdma_chan #(.AW(AW), .DW(DW), .CW(CW), .GW(GW), .EVD(EVD)) i_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_sel),
            .wr_idx   (idx),
            .wr_data  (reg_wdata),
            .start_in (start[g]),
            .ev_in    (ev_pulse[g]),
            .gnt      (ch_gnt[g]),
            .rdata    (bus_rdata),
            .req      (ch_req[g]),
            .we       (ch_we[g]),
            .addr     (ch_addr[g]),
            .wdata    (ch_wdata[g]),
            .done     (done[g]),
            .busy     (busy[g]),
            .ctrl_o   (ctrl_v[g]),
            .src_o    (src_v[g]),
            .dst_o    (dst_v[g]),
            .cnt_o    (cnt_v[g]),
            .gap_o    (gap_v[g])
        );
    end

    pdma_arb #(.AW(AW), .DW(DW)) i_arb (
        .clk       (clk),
        .rst       (rst),
        .ch_req    (ch_req),
        .ch_we     (ch_we),
        .ch_addr   (ch_addr),
        .ch_wdata  (ch_wdata),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ch_gnt    (ch_gnt)
    );

    assign clr_mask = (reg_we && idx == IDX_STAT) ? reg_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr_mask) | done;
    end

    assign irq = |(stat & ien);

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_CTRL: reg_rdata = DW'({ctrl_v[csel], busy[csel]});
            IDX_SRC:  reg_rdata = DW'(src_v[csel]);
            IDX_DST:  reg_rdata = DW'(dst_v[csel]);
            IDX_CNT:  reg_rdata = DW'(cnt_v[csel]);
            IDX_GAP:  reg_rdata = DW'(gap_v[csel]);
            IDX_STAT: reg_rdata = DW'(stat);
            default:  reg_rdata = '0;
        endcase
    end

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat[0] && !clr_mask[0]) |=> stat[0]); // R12
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        done[1] |=> stat[1]); // R9
    AST_LINK_START: assert property (@(posedge clk) disable iff (rst)
        (done[0] && link[0] && !busy[1] && cnt_v[1] != '0) |=> busy[1]); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat != '0)); // R12

endmodule

// File: tb/test_pdma_top.sv
`timescale 1ns/1ps
module test_pdma_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ev_pulse = '0;
    logic        bus_req, bus_we, bus_gnt, irq;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        stall = 1'b0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pctr = 100;
    int plen = 0;
    int wn = 0;
    logic [31:0] wmem [256];
    logic [31:0] plog [64];
    int          wtime [512];

    always #4 clk = ~clk;

    assign bus_gnt = bus_req && !stall;

    pdma_top i_pdma_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {a, ~a, 8'h5A, a ^ 8'h3C};
    endfunction

    function automatic logic [31:0] ctrlw(input logic en, input logic [1:0] op,
            input logic [1:0] trig, input logic fix, input logic lnk, input logic ie);
        return {24'd0, ie, lnk, fix, trig, op, en};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_req && bus_gnt) begin
            if (bus_we) begin
                if (bus_addr[7:0] == 8'hFF) begin
                    plog[plen % 64] <= bus_wdata;
                    plen <= plen + 1;
                end else begin
                    wmem[bus_addr[7:0]] <= bus_wdata;
                end
                wtime[wn % 512] <= cyc;
                wn <= wn + 1;
            end else begin
                if (bus_addr[7:0] == 8'hFF) begin
                    bus_rdata <= pctr;
                    pctr <= pctr + 1;
                end else begin
                    bus_rdata <= pat(bus_addr[7:0]);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic ch, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_addr = {ch, idx}; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic ch, input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {ch, idx};
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input logic ch);
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            rreg(ch, 3'd0, v);
            if (v[0] == 1'b0) return;
        end
        chk("timeout waiting for idle", 32'd1, 32'd0);
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq) return;
        end
        chk("R9 timeout waiting for irq", 32'd0, 32'd1);
    endtask

    task automatic setup(input logic ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] n, input logic [7:0] g);
        wreg(ch, 3'd1, {16'd0, s});
        wreg(ch, 3'd2, {16'd0, d});
        wreg(ch, 3'd3, {16'd0, n});
        wreg(ch, 3'd4, {24'd0, g});
    endtask

    initial begin
        #1520000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w0, p0, l0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 6; i++) begin
                rreg(c[0], i[2:0], v);
                chk("R1 register after reset", v, 32'd0);
            end
        end
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2 + R11: copy sweep over both channels and lengths
        for (int c = 0; c < 2; c++) begin
            for (int n = 1; n <= 4; n++) begin
                logic [15:0] s, d;
                s = 16'h20 + 16'(n * 3 + c);
                d = 16'h40 + 16'(c * 16 + (n - 1) * 4);
                setup(c[0], s, d, 16'(n), 8'd0);
                wreg(c[0], 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 0, 0));
                wait_idle(c[0]);
                for (int i = 0; i < n; i++)
                    chk("R2 copied word", wmem[d[7:0] + 8'(i)], pat(s[7:0] + 8'(i)));
                rreg(c[0], 3'd1, v);
                chk("R2 source after copy", v, 32'(s) + 32'(n));
                rreg(c[0], 3'd3, v);
                chk("R11 remaining count zero", v, 32'd0);
                wreg(1'b0, 3'd5, 32'd3);
            end
        end

        // R3: peripheral to memory with fixed source
        p0 = pctr;
        setup(1'b0, 16'h00FF, 16'h0090, 16'd4, 8'd0);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd0, 2'd0, 1, 0, 0));
        wait_idle(1'b0);
        for (int i = 0; i < 4; i++)
            chk("R3 peripheral word stored", wmem[8'h90 + 8'(i)], 32'(p0 + i));
        rreg(1'b0, 3'd1, v);
        chk("R3 fixed source unchanged", v, 32'h00FF);
        rreg(1'b0, 3'd2, v);
        chk("R3 memory side advanced", v, 32'h0094);

        // R3: memory to peripheral with fixed destination
        l0 = plen;
        setup(1'b1, 16'h0030, 16'h00FF, 16'd3, 8'd0);
        wreg(1'b1, 3'd0, ctrlw(1, 2'd1, 2'd0, 1, 0, 0));
        wait_idle(1'b1);
        for (int i = 0; i < 3; i++)
            chk("R3 peripheral received", plog[(l0 + i) % 64], pat(8'h30 + 8'(i)));
        rreg(1'b1, 3'd2, v);
        chk("R3 fixed destination unchanged", v, 32'h00FF);

        // R4 / R5: beat spacing for free-run and throttled
        for (int gi = 0; gi < 4; gi++) begin
            int g;
            g = (gi == 0) ? 0 : (gi == 1) ? 1 : (gi == 2) ? 3 : 6;
            w0 = wn;
            setup(1'b0, 16'h0010, 16'h0080, 16'd4, 8'(g));
            wreg(1'b0, 3'd0, ctrlw(1, 2'd2, (gi == 0) ? 2'd0 : 2'd1, 0, 0, 0));
            wait_idle(1'b0);
            for (int k = 0; k < 3; k++)
                chk((gi == 0) ? "R4 free-run spacing" : "R5 throttled spacing",
                    32'(wtime[(w0 + k + 1) % 512] - wtime[(w0 + k) % 512]), 32'(4 + g));
        end
        wreg(1'b0, 3'd5, 32'd3);

        // R11: enable with zero count stays idle
        wreg(1'b0, 3'd3, 32'd0);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 0, 1));
        rreg(1'b0, 3'd0, v);
        chk("R11 zero-count enable busy bit", {31'd0, v[0]}, 32'd0);
        rreg(1'b0, 3'd5, v);
        chk("R11 zero-count enable no status", v, 32'd0);
        chk("R11 zero-count enable no request", {31'd0, bus_req}, 32'd0);

        // R11: writes while busy are ignored
        setup(1'b0, 16'h0010, 16'h0080, 16'd3, 8'd20);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd2, 2'd1, 0, 0, 0));
        wreg(1'b0, 3'd4, 32'd5);
        wreg(1'b0, 3'd0, 32'd0);
        rreg(1'b0, 3'd4, v);
        chk("R11 gap write while busy", v, 32'd20);
        rreg(1'b0, 3'd0, v);
        chk("R11 ctrl write while busy", {31'd0, v[0]}, 32'd1);
        wait_idle(1'b0);
        wreg(1'b0, 3'd5, 32'd3);

        // R6 / R7: event pacing on channel 1
        setup(1'b1, 16'h0010, 16'h00A0, 16'd10, 8'd0);
        wreg(1'b1, 3'd0, ctrlw(1, 2'd2, 2'd2, 0, 0, 0));
        repeat (30) @(negedge clk);
        rreg(1'b1, 3'd3, v);
        chk("R6 no word without event", v, 32'd10);
        @(negedge clk); ev_pulse = 2'b10;
        @(negedge clk); ev_pulse = 2'b00;
        repeat (20) @(negedge clk);
        rreg(1'b1, 3'd3, v);
        chk("R6 one word per pulse", v, 32'd9);
        stall = 1'b1;
        @(negedge clk); ev_pulse = 2'b10;
        repeat (6) @(negedge clk);
        ev_pulse = 2'b00;
        repeat (3) @(negedge clk);
        stall = 1'b0;
        repeat (100) @(negedge clk);
        rreg(1'b1, 3'd3, v);
        chk("R7 queued pulses capped at four", v, 32'd4);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ev_pulse = 2'b10;
            @(negedge clk); ev_pulse = 2'b00;
            repeat (12) @(negedge clk);
        end
        rreg(1'b1, 3'd0, v);
        chk("R6 event channel finished", {31'd0, v[0]}, 32'd0);
        for (int i = 0; i < 10; i++)
            chk("R6 event copy data", wmem[8'hA0 + 8'(i)], pat(8'h10 + 8'(i)));
        wreg(1'b0, 3'd5, 32'd3);

        // R8: linking ch0 -> ch1
        setup(1'b1, 16'h0050, 16'h00C0, 16'd2, 8'd0);
        wreg(1'b1, 3'd0, ctrlw(0, 2'd2, 2'd0, 0, 0, 0));
        setup(1'b0, 16'h0058, 16'h00C8, 16'd2, 8'd0);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 1, 0));
        wait_idle(1'b0);
        wait_idle(1'b1);
        for (int i = 0; i < 2; i++) begin
            chk("R8 first channel data", wmem[8'hC8 + 8'(i)], pat(8'h58 + 8'(i)));
            chk("R8 linked channel data", wmem[8'hC0 + 8'(i)], pat(8'h50 + 8'(i)));
        end

        // R12: status sticky, masked irq, write-one-to-clear
        rreg(1'b0, 3'd5, v);
        chk("R12 both status bits set", v, 32'd3);
        chk("R12 masked irq low", {31'd0, irq}, 32'd0);
        wreg(1'b1, 3'd5, 32'd1);
        rreg(1'b0, 3'd5, v);
        chk("R12 clear one bit only", v, 32'd2);
        wreg(1'b0, 3'd5, 32'd2);

        // R9: ping-pong pair
        setup(1'b1, 16'h0060, 16'h00B4, 16'd8, 8'd0);
        wreg(1'b1, 3'd0, ctrlw(0, 2'd2, 2'd0, 0, 1, 1));
        setup(1'b0, 16'h0068, 16'h00B0, 16'd2, 8'd0);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 1, 1));
        wait_irq();
        rreg(1'b1, 3'd0, v);
        chk("R9 partner running after first half", {31'd0, v[0]}, 32'd1);
        rreg(1'b0, 3'd5, v);
        chk("R9 status after first half", v, 32'd1);
        wreg(1'b0, 3'd5, 32'd1);
        chk("R12 irq drops after clear", {31'd0, irq}, 32'd0);
        setup(1'b0, 16'h0038, 16'h00D0, 16'd3, 8'd0);
        wait_irq();
        rreg(1'b0, 3'd5, v);
        chk("R9 status after second half", v, 32'd2);
        rreg(1'b0, 3'd0, v);
        chk("R9 reloaded channel restarted", {31'd0, v[0]}, 32'd1);
        wait_idle(1'b0);
        for (int i = 0; i < 3; i++)
            chk("R9 reloaded channel data", wmem[8'hD0 + 8'(i)], pat(8'h38 + 8'(i)));
        for (int i = 0; i < 8; i++)
            chk("R9 partner data", wmem[8'hB4 + 8'(i)], pat(8'h60 + 8'(i)));
        rreg(1'b1, 3'd0, v);
        chk("R8 zero-count partner not started", {31'd0, v[0]}, 32'd0);
        wreg(1'b0, 3'd5, 32'd3);

        // R10: simultaneous requests
        stall = 1'b1;
        setup(1'b1, 16'h0070, 16'h00E0, 16'd1, 8'd0);
        wreg(1'b1, 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 0, 0));
        setup(1'b0, 16'h0078, 16'h00E8, 16'd1, 8'd0);
        wreg(1'b0, 3'd0, ctrlw(1, 2'd2, 2'd0, 0, 0, 0));
        repeat (3) @(negedge clk);
        stall = 1'b0;
        #1;
        chk("R10 channel 0 wins the grant", {16'd0, bus_addr}, 32'h0078);
        wait_idle(1'b0);
        wait_idle(1'b1);
        chk("R10 channel 0 data", wmem[8'hE8], pat(8'h78));
        chk("R10 channel 1 data", wmem[8'hE0], pat(8'h70));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule